// File: doc/BRIEF.md
# Sine-Triangle PWM Leg Controller

This block drives the two switches of one inverter half-bridge with sinusoidal pulse-width modulation. A symmetric triangle carrier, counted directly in clock cycles, is compared against a sine reference. The reference comes from a single 128-step sine built from a quarter-wave table. The table position is a phase accumulator that gains the selected output frequency once per sample strobe. This is the same as a free-running sample count multiplied by the frequency, wrapped at the number of samples per second.

The sine swing shrinks in proportion to the selected frequency, so the volts-per-hertz ratio of the filtered output stays fixed. The highest frequency uses the full carrier range. The comparator result goes through a dead-time stage, which produces an upper and a lower switch command that are complementary. Neither command turns on until both have been off for a programmable number of cycles.

The user selects the frequency as an integer word. The block takes a new value only when the carrier reaches its valley. Dropping the enable parks both switches off and clears all counters.

Top module: `spwm_leg_ctrl`

## Requirements
- R1: The carrier steps by one count per enabled clock from 0 up to TRI_MAX and back down to 0, so its period is exactly 2*TRI_MAX clocks whatever frequency is selected.
- R2: A sample strobe fires once every CLK_PER_SAMPLE enabled clocks, the first on the CLK_PER_SAMPLE-th enabled edge. Each strobe advances the phase by the active frequency, modulo SAMPLES_PER_SEC.
- R3: The switching decision is high when the reference is strictly greater than the carrier. The reference is TRI_MAX/2 + (f/FMAX)*(TRI_MAX/2)*sin(2*pi*phase/SAMPLES_PER_SEC), with the sine angle quantised to 128 steps per period. The outputs follow a decision three clocks after the phase and frequency it was built from.
- R4: The sine swing scales linearly with the active frequency f: at f = FMAX the reference spans 0 to TRI_MAX, and at f = FMAX/2 it spans half of that around the midpoint.
- R5: The upper output follows the decision and the lower output follows its inverse. They are never both high. Before either turns on, both have been low for at least DEAD_CYCLES clocks, so a decision held for fewer cycles produces no pulse.
- R6: A new frequency select is taken only on a clock where the carrier is at 0. A change at any other point has no effect until the next valley.
- R7: A select of 0 acts as 1, and a select above FMAX acts as FMAX.
- R8: While en is low, both outputs are low from the next clock. The phase, divider and carrier are cleared, so re-enabling restarts at phase 0 with the carrier at 0.
- R9: While rst (synchronous, active high) is asserted, both outputs are low and all state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks outputs and clears counters |
| fsel | input | $clog2(FMAX+1) | Requested output frequency in hertz |
| pwm_hi | output | 1 | Upper switch command |
| pwm_lo | output | 1 | Lower switch command |

## Verification
The frequency reload at the carrier valley can fall in the same cycle as a sample strobe. A select change can also land in the middle of a carrier period, between two valleys. The bench changes the select at chosen carrier positions and holds the clock-per-sample divider so that strobes and valleys meet repeatedly. An independent model predicts the switch state from a real-valued sine, using the old frequency until the valley and the new one after it. The bench compares the outputs wherever the reference and the carrier differ by a clear margin, and it checks every turn-on for overlap and for the minimum off gap.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;

    typedef enum logic {SLOPE_UP = 1'b0, SLOPE_DOWN = 1'b1} slope_e;

    // Magnitude of 2047*sin(k*pi/64) for k = 0..32 (first quadrant, inclusive of peak)
    function automatic logic [10:0] quarter_mag(input logic [5:0] k);
        logic [10:0] m;
        case (k)
            6'd0:  m = 11'd0;
            6'd1:  m = 11'd100;
            6'd2:  m = 11'd201;
            6'd3:  m = 11'd300;
            6'd4:  m = 11'd399;
            6'd5:  m = 11'd497;
            6'd6:  m = 11'd594;
            6'd7:  m = 11'd690;
            6'd8:  m = 11'd783;
            6'd9:  m = 11'd875;
            6'd10: m = 11'd965;
            6'd11: m = 11'd1052;
            6'd12: m = 11'd1137;
            6'd13: m = 11'd1219;
            6'd14: m = 11'd1299;
            6'd15: m = 11'd1375;
            6'd16: m = 11'd1447;
            6'd17: m = 11'd1517;
            6'd18: m = 11'd1582;
            6'd19: m = 11'd1644;
            6'd20: m = 11'd1702;
            6'd21: m = 11'd1756;
            6'd22: m = 11'd1805;
            6'd23: m = 11'd1850;
            6'd24: m = 11'd1891;
            6'd25: m = 11'd1927;
            6'd26: m = 11'd1959;
            6'd27: m = 11'd1986;
            6'd28: m = 11'd2008;
            6'd29: m = 11'd2025;
            6'd30: m = 11'd2037;
            6'd31: m = 11'd2045;
            default: m = 11'd2047;
        endcase
        return m;
    endfunction

    // Signed sine over 128 steps per period, peak 2047
    function automatic logic signed [11:0] sine_at(input logic [6:0] idx);
        logic [5:0]  k;
        logic [10:0] m;
        k = idx[5] ? (6'd32 - {1'b0, idx[4:0]}) : {1'b0, idx[4:0]};
        m = quarter_mag(k);
        return idx[6] ? -$signed({1'b0, m}) : $signed({1'b0, m});
    endfunction

endpackage

// File: rtl/spwm_carrier.sv
`timescale 1ns/1ps
module spwm_carrier
    import spwm_pkg::*;
#(
    parameter int TRI_MAX = 1666
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en_i,
    output logic [$clog2(TRI_MAX+1)-1:0]   tri_o,
    output logic                           valley_o
);
    localparam int TRI_W = $clog2(TRI_MAX + 1);

    typedef struct packed {
        logic [TRI_W-1:0] level;
        slope_e           slope;
    } car_t;

    car_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.level = '0;
            st_d.slope = SLOPE_UP;
        end else if (st_q.slope == SLOPE_UP) begin
            st_d.level = st_q.level + 1'b1;
            if (st_q.level == TRI_W'(TRI_MAX - 1)) st_d.slope = SLOPE_DOWN;
        end else begin
            st_d.level = st_q.level - 1'b1;
            if (st_q.level == TRI_W'(1)) st_d.slope = SLOPE_UP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level <= '0;
            st_q.slope <= SLOPE_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign tri_o    = st_q.level;
    assign valley_o = (st_q.level == '0);

    AST_TRI_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.level <= TRI_W'(TRI_MAX)); // R1
    AST_TRI_TURN: assert property (@(posedge clk) disable iff (rst)
        (en_i && st_q.level == TRI_W'(TRI_MAX)) |=> (st_q.level == TRI_W'(TRI_MAX - 1))); // R1

endmodule

// File: rtl/spwm_reference.sv
`timescale 1ns/1ps
module spwm_reference
    import spwm_pkg::*;
#(
    parameter int CLK_PER_SAMPLE  = 333,
    parameter int SAMPLES_PER_SEC = 150000,
    parameter int TRI_MAX         = 1666,
    parameter int FMAX            = 60
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en_i,
    input  logic                           valley_i,
    input  logic [$clog2(FMAX+1)-1:0]      fsel_i,
    output logic [$clog2(TRI_MAX+1)-1:0]   level_o
);
    localparam int DIV_W  = $clog2(CLK_PER_SAMPLE + 1);
    localparam int PH_W   = $clog2(SAMPLES_PER_SEC + 1);
    localparam int F_W    = $clog2(FMAX + 1);
    localparam int TRI_W  = $clog2(TRI_MAX + 1);
    localparam int HALF   = TRI_MAX / 2;
    localparam int IDX_SH = 24;
    localparam int AMP_SH = 24;
    localparam longint RECIP = (longint'(128) <<< IDX_SH) / longint'(SAMPLES_PER_SEC);
    localparam longint AMP_K = ((longint'(HALF) <<< AMP_SH) + longint'(2047 * FMAX / 2))
                               / longint'(2047 * FMAX);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  phase;
        logic [F_W-1:0]   freq;
        logic [TRI_W-1:0] level;
    } ref_t;

    ref_t st_d, st_q;

    logic [F_W-1:0]      freq_req;
    logic                strobe;
    logic [PH_W:0]       ph_sum;
    logic [63:0]         scaled;
    logic [6:0]          idx;
    logic signed [11:0]  sine;
    longint              prod;
    longint              lvl;

    always_comb begin
        if (fsel_i == '0)                  freq_req = F_W'(1);
        else if (fsel_i > F_W'(FMAX))      freq_req = F_W'(FMAX);
        else                               freq_req = fsel_i;

        strobe = (st_q.div == DIV_W'(CLK_PER_SAMPLE - 1));
        ph_sum = {1'b0, st_q.phase} + (PH_W+1)'(st_q.freq);
        if (ph_sum >= (PH_W+1)'(SAMPLES_PER_SEC))
            ph_sum = ph_sum - (PH_W+1)'(SAMPLES_PER_SEC);

        scaled = 64'(st_q.phase) * 64'(RECIP);
        idx    = 7'(scaled >> IDX_SH);
        sine   = sine_at(idx);
        prod   = longint'(sine) * longint'(st_q.freq) * AMP_K;
        lvl    = longint'(HALF) + (prod >>> AMP_SH);
        if (lvl < 0)                     lvl = 0;
        if (lvl > longint'(TRI_MAX))     lvl = longint'(TRI_MAX);

        st_d = st_q;
        if (!en_i) begin
            st_d.div   = '0;
            st_d.phase = '0;
            st_d.freq  = freq_req;
            st_d.level = '0;
        end else begin
            st_d.div   = strobe ? '0 : st_q.div + 1'b1;
            if (strobe) st_d.phase = PH_W'(ph_sum);
            if (valley_i) st_d.freq = freq_req;
            st_d.level = TRI_W'(lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.div   <= '0;
            st_q.phase <= '0;
            st_q.freq  <= F_W'(1);
            st_q.level <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        st_q.phase < PH_W'(SAMPLES_PER_SEC)); // R2
    AST_FREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (en_i && !valley_i) |=> $stable(st_q.freq)); // R6
    AST_FREQ_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q.freq >= F_W'(1)) && (st_q.freq <= F_W'(FMAX))); // R7
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.level <= TRI_W'(TRI_MAX)); // R3

endmodule

// File: rtl/spwm_deadtime.sv
`timescale 1ns/1ps
module spwm_deadtime #(
    parameter int DEAD_CYCLES = 25,
    parameter int TRI_W       = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [TRI_W-1:0] level_i,
    input  logic [TRI_W-1:0] tri_i,
    output logic             hi_o,
    output logic             lo_o
);
    localparam int HOLD_W = $clog2(DEAD_CYCLES + 2);

    typedef struct packed {
        logic              cmp;
        logic              cmp_prev;
        logic [HOLD_W-1:0] hold;
        logic              hi;
        logic              lo;
    } dt_t;

    dt_t st_d, st_q;
    logic [HOLD_W-1:0] hold_next;

    always_comb begin
        if (st_q.cmp != st_q.cmp_prev)                 hold_next = '0;
        else if (st_q.hold >= HOLD_W'(DEAD_CYCLES))    hold_next = HOLD_W'(DEAD_CYCLES);
        else                                           hold_next = st_q.hold + 1'b1;

        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.cmp      = (level_i > tri_i);
            st_d.cmp_prev = st_q.cmp;
            st_d.hold     = hold_next;
            st_d.hi       =  st_q.cmp && (hold_next >= HOLD_W'(DEAD_CYCLES));
            st_d.lo       = !st_q.cmp && (hold_next >= HOLD_W'(DEAD_CYCLES));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(st_q.hi && st_q.lo)); // R5
    AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.hi) |-> !$past(st_q.lo)); // R5
    AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.lo) |-> !$past(st_q.hi)); // R5
    AST_PARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!st_q.hi && !st_q.lo)); // R8

endmodule

// File: rtl/spwm_leg_ctrl.sv
`timescale 1ns/1ps
module spwm_leg_ctrl #(
    parameter int CLK_PER_SAMPLE  = 333,
    parameter int SAMPLES_PER_SEC = 150000,
    parameter int TRI_MAX         = 1666,
    parameter int FMAX            = 60,
    parameter int DEAD_CYCLES     = 25
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [$clog2(FMAX+1)-1:0] fsel,
    output logic                      pwm_hi,
    output logic                      pwm_lo
);
    localparam int TRI_W = $clog2(TRI_MAX + 1);

    logic [TRI_W-1:0] carrier;
    logic             valley;
    logic [TRI_W-1:0] level;

    spwm_carrier #(.TRI_MAX(TRI_MAX)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .tri_o    (carrier),
        .valley_o (valley)
    );

    spwm_reference #(
        .CLK_PER_SAMPLE  (CLK_PER_SAMPLE),
        .SAMPLES_PER_SEC (SAMPLES_PER_SEC),
        .TRI_MAX         (TRI_MAX),
        .FMAX            (FMAX)
    ) u_reference (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .valley_i (valley),
        .fsel_i   (fsel),
        .level_o  (level)
    );

    spwm_deadtime #(
        .DEAD_CYCLES (DEAD_CYCLES),
        .TRI_W       (TRI_W)
    ) u_deadtime (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .level_i (level),
        .tri_i   (carrier),
        .hi_o    (pwm_hi),
        .lo_o    (pwm_lo)
    );

    AST_RESET_PARK: assert property (@(posedge clk)
        rst |=> (!pwm_hi && !pwm_lo)); // R9

endmodule

// File: tb/spwm_leg_ctrl_bench.sv
`timescale 1ns/1ps
module spwm_leg_ctrl_bench;

    localparam int  CPS    = 10;
    localparam int  NS     = 2400;
    localparam int  TMAX   = 20;
    localparam int  FMAX   = 60;
    localparam int  DT     = 3;
    localparam int  FW     = $clog2(FMAX + 1);
    localparam real HALF   = TMAX / 2;
    localparam real MARGIN = 2.5;
    localparam real TWO_PI = 6.283185307179586;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [FW-1:0] fsel = FW'(60);
    logic          pwm_hi, pwm_lo;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    spwm_leg_ctrl #(
        .CLK_PER_SAMPLE  (CPS),
        .SAMPLES_PER_SEC (NS),
        .TRI_MAX         (TMAX),
        .FMAX            (FMAX),
        .DEAD_CYCLES     (DT)
    ) u_spwm_leg_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .fsel   (fsel),
        .pwm_hi (pwm_hi),
        .pwm_lo (pwm_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int clampf(input int v);
        if (v == 0) return 1;
        if (v > FMAX) return FMAX;
        return v;
    endfunction

    function automatic real ref_model(input int ph, input int f);
        return HALF + (real'(f) / FMAX) * HALF * $sin(TWO_PI * real'(ph) / NS);
    endfunction

    // expected item for the outputs after one clock edge
    typedef struct {
        bit dis;
        bit in_rst;
        bit chk_on;
        bit chk_off;
        bit d;
    } exp_t;

    exp_t exp_q[$];

    // model state, updated per edge from the requirement text
    int md = 0, mph = 0, mtri = 0, mf = 1, since_en = 0, run = 0;
    bit mup = 1, dlast = 0;
    int hph[4], hf[4], htri[4];

    always @(posedge clk) begin
        exp_t it;
        int   nd, nph, ntri, nf;
        bit   nup, strobe, conf, dn;
        real  r, diff;
        it = '{default: 0};
        if (rst || !en) begin
            md = 0; mph = 0; mtri = 0; mup = 1;
            mf = rst ? 1 : clampf(int'(fsel));
            since_en = 0; run = 0;
            it.dis = 1; it.in_rst = rst;
        end else begin
            strobe = (md == CPS - 1);
            nd   = strobe ? 0 : md + 1;
            nph  = strobe ? (mph + mf) % NS : mph;
            nf   = (mtri == 0) ? clampf(int'(fsel)) : mf;
            if (mup) begin ntri = mtri + 1; nup = (ntri != TMAX); end
            else     begin ntri = mtri - 1; nup = (ntri == 0); end
            md = nd; mph = nph; mf = nf; mtri = ntri; mup = nup;
            since_en++;
        end
        for (int i = 3; i > 0; i--) begin
            hph[i] = hph[i-1]; hf[i] = hf[i-1]; htri[i] = htri[i-1];
        end
        hph[0] = mph; hf[0] = mf; htri[0] = mtri;
        if (!it.dis && since_en >= 4) begin
            r    = ref_model(hph[3], hf[3]);
            diff = r - real'(htri[2]);
            conf = (diff > MARGIN) || (diff < -MARGIN);
            dn   = (diff > 0.0);
            if (conf) begin
                run   = (run > 0 && dn == dlast) ? run + 1 : 1;
                dlast = dn;
            end else begin
                run = 0;
            end
            it.chk_off = conf;
            it.chk_on  = conf && (run >= DT + 1);
            it.d       = dn;
        end
        exp_q.push_back(it);
    end

    // monitor: pops one expectation per clock and compares at the falling edge
    bit prev_hi = 0, prev_lo = 0;
    int lowrun = 100, cyc = 0, last_rise = -1, rise_cnt = 0;

    always @(negedge clk) begin
        exp_t it;
        cyc++;
        if (exp_q.size() > 0 && !done) begin
            it = exp_q.pop_front();
            if (pwm_hi && pwm_lo)
                check(0, "R5", "both switches on", 1, 0);
            if ((pwm_hi && !prev_hi) || (pwm_lo && !prev_lo))
                check(lowrun >= DT, "R5", "off gap before turn-on", lowrun, DT);
            if (it.dis) begin
                check(!pwm_hi && !pwm_lo, it.in_rst ? "R9" : "R8",
                      "parked outputs hi/lo", {pwm_hi, pwm_lo}, 0);
            end else if (it.chk_on) begin
                check(pwm_hi == it.d && pwm_lo == !it.d, cur_req,
                      "R3 switch state hi/lo", {pwm_hi, pwm_lo}, {it.d, !it.d});
            end else if (it.chk_off) begin
                check(it.d ? !pwm_lo : !pwm_hi, cur_req,
                      "R3 opposite switch off hi/lo", {pwm_hi, pwm_lo}, {1'b0, 1'b0});
            end
            if (cur_req == "R1" && pwm_hi && !prev_hi) begin
                rise_cnt++;
                if (rise_cnt > 2)
                    check((cyc - last_rise) >= 2*TMAX - 1 && (cyc - last_rise) <= 2*TMAX + 1,
                          "R1", "carrier period in clocks", cyc - last_rise, 2*TMAX);
                last_rise = cyc;
            end
        end
        lowrun  = (!pwm_hi && !pwm_lo) ? lowrun + 1 : 0;
        prev_hi = pwm_hi;
        prev_lo = pwm_lo;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tri(input int lvl, input bit rising);
        do @(negedge clk); while (!(mtri == lvl && mup == rising));
    endtask

    initial begin
        wait_clks(5);
        // R9: reset state
        check(!pwm_hi && !pwm_lo, "R9", "outputs in reset", {pwm_hi, pwm_lo}, 0);
        rst = 1'b0;
        wait_clks(3);
        check(!pwm_hi && !pwm_lo, "R8", "outputs idle while disabled", {pwm_hi, pwm_lo}, 0);

        // R2: full-scale frequency, phase stepping by the select
        cur_req = "R2";
        fsel = FW'(60);
        en   = 1'b1;
        wait_clks(900);

        // R4: half frequency, half swing
        cur_req = "R4";
        fsel = FW'(30);
        wait_clks(900);

        // R6: select changes between valleys, taken at the next valley only
        cur_req = "R6";
        wait_tri(7, 1'b1);
        fsel = FW'(5);
        wait_clks(900);
        wait_tri(15, 1'b0);
        fsel = FW'(45);
        wait_clks(600);

        // R7: out-of-range selects clamp
        cur_req = "R7";
        fsel = FW'(63);
        wait_clks(600);
        fsel = FW'(0);
        wait_clks(600);

        // R8: disable mid-run parks outputs and restarts cleanly
        cur_req = "R8";
        fsel = FW'(60);
        wait_tri(9, 1'b1);
        en = 1'b0;
        wait_clks(2);
        check(!pwm_hi && !pwm_lo, "R8", "outputs after disable", {pwm_hi, pwm_lo}, 0);
        wait_clks(20);
        en = 1'b1;
        wait_clks(600);

        // R1: near-constant reference, one pulse per carrier period
        cur_req = "R1";
        fsel = FW'(1);
        wait_clks(800);
        check(rise_cnt >= 10, "R1", "upper pulses seen", rise_cnt, 10);

        // R9: reset in the middle of operation
        cur_req = "R9";
        rst = 1'b1;
        wait_clks(3);
        check(!pwm_hi && !pwm_lo, "R9", "outputs under reset", {pwm_hi, pwm_lo}, 0);
        rst = 1'b0;
        en  = 1'b0;
        wait_clks(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule